// File: doc/BRIEF.md
# Self-Compacting Marker-Chain FIFO

This block is a small elastic queue of sixteen 4-bit words. It has no read or write pointers. Storage is a chain of stages, and each stage holds one word and one occupancy marker. A stage that is vacant copies the word from the occupied stage on its input side, so words move toward the output end and vacancies move toward the input end with no action from outside.

Words enter through a shift-in strobe and leave through a shift-out strobe. The two strobes are independent, so the producer and the consumer can run at different rates. Two flags report the state of the end stages:

- The input-ready flag is high while the first stage is vacant. This means the queue can take a word.
- The output-ready flag is high while the last stage is occupied. This means a word is waiting at the output.

Because the flags describe only the end stages, several instances can be chained by driving one block's shift-in from the previous block's output-ready. An output-enable input gates the data output only. A synchronous reset empties the chain.

Top module: `bubble_fifo`

## Requirements
- R1: While `rst` is high at a clock edge, every marker is cleared. After that edge, `in_rdy` reads 1 and `out_rdy` reads 0.
- R2: Words leave in the same order in which they were accepted, with their 4-bit values unchanged.
- R3: The chain accepts exactly 16 words. Once 16 words are held and have settled, `in_rdy` is 0.
- R4: A `shift_in` pulse while `in_rdy` is 0 stores nothing. After such a pulse, draining the queue yields only the words that were accepted earlier.
- R5: A `shift_out` pulse while `out_rdy` is 0 removes nothing and creates no word.
- R6: A word accepted into an empty chain at clock edge k makes `out_rdy` read 1 after edge k+15, and not after edge k+14. A word advances one stage per clock.
- R7: When `oe` is 0, `dout` reads 0. A `shift_out` with `oe` at 0 still removes the word. When `oe` is 1 and `out_rdy` is 1, `dout` carries the oldest word.
- R8: A vacancy moves one stage per clock toward the input end. After one word is removed from a full chain at edge k, `in_rdy` reads 0 after edge k+14 and reads 1 after edge k+15.
- R9: A `shift_out` accepted at edge k clears `out_rdy` after edge k. If the neighbouring stage holds a word, `out_rdy` returns to 1 after edge k+1.
- R10: A `shift_in` that arrives together with a `shift_out` is accepted only if the first stage was vacant before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high. Empties the chain. |
| shift_in | input | 1 | Strobe that loads `din` into the first stage when `in_rdy` is 1 |
| din | input | 4 | Word to be written |
| shift_out | input | 1 | Strobe that removes the word in the last stage when `out_rdy` is 1 |
| oe | input | 1 | Output enable. Gates `dout` only. |
| dout | output | 4 | Word in the last stage, or 0 while `oe` is 0 |
| in_rdy | output | 1 | First stage is vacant (not full) |
| out_rdy | output | 1 | Last stage is occupied (data available) |

## Verification
The main function is exercised with four kinds of traffic, and each one exposes a different kind of fault:

- **Table of mixed words.** Distinct words are written and then read back with the output enable toggled from word to word. Any mismatch in order, in value or in the output gating shows up here.
- **Single word into an empty chain.** This traffic measures the fall-through time. It separates a chain that advances one stage per clock from one that skips stages or stalls.
- **Filling to capacity, then one extra write.** This confirms that the capacity is sixteen words and that a write to a full chain is dropped.
- **One read from a full chain.** This shows the last stage clearing and refilling. It also shows the vacancy travelling back, so `in_rdy` returns at exactly the expected edge.

Reads from an empty chain and a reset in the middle of traffic complete the coverage.

// File: rtl/bubble_fifo_pkg.sv
package bubble_fifo_pkg;

  // A stage pulls from its upstream neighbour when it is vacant and the
  // neighbour is occupied; both inputs are last cycle's markers.
  function automatic logic stage_pulls(input logic self_full, input logic up_full);
    return !self_full && up_full;
  endfunction

  // Marker update for one stage: a take wins over a give, which cannot
  // happen together anyway because a take needs the stage to be vacant.
  function automatic logic next_marker(input logic cur, input logic take, input logic give);
    return take ? 1'b1 : (give ? 1'b0 : cur);
  endfunction

endpackage

// File: rtl/bubble_stage.sv
module bubble_stage #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             give,
  input  logic [WIDTH-1:0] src_word,
  output logic             full_q,
  output logic [WIDTH-1:0] word_q
);
  import bubble_fifo_pkg::*;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b0;
      word_q <= '0;
    end else begin
      full_q <= next_marker(full_q, take, give);
      if (take) word_q <= src_word;
    end
  end

endmodule

// File: rtl/bubble_out_gate.sv
module bubble_out_gate #(
  parameter int WIDTH = 4
) (
  input  logic             en,
  input  logic [WIDTH-1:0] word,
  output logic [WIDTH-1:0] gated
);

  always_comb begin
    gated = en ? word : '0;
  end

endmodule

// File: rtl/bubble_fifo.sv
module bubble_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             shift_in,
  input  logic [WIDTH-1:0] din,
  input  logic             shift_out,
  input  logic             oe,
  output logic [WIDTH-1:0] dout,
  output logic             in_rdy,
  output logic             out_rdy
);
  import bubble_fifo_pkg::*;

  localparam int LAST = DEPTH - 1;

  // Per-stage markers and words, index 0 at the input end.
  logic [DEPTH-1:0] mark_q;
  logic [WIDTH-1:0] word_q [DEPTH];

  // Named events for the checker.
  logic [DEPTH-1:0] take_ev;
  logic [DEPTH-1:0] give_ev;
  logic             load_ev;
  logic             unload_ev;

  assign in_rdy    = !mark_q[0];
  assign out_rdy   = mark_q[LAST];
  assign load_ev   = shift_in && in_rdy;
  assign unload_ev = shift_out && out_rdy;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [WIDTH-1:0] src;

    if (i == 0) begin : g_head
      assign take_ev[i] = load_ev;
      assign src        = din;
    end else begin : g_body
      assign take_ev[i] = stage_pulls(mark_q[i], mark_q[i-1]);
      assign src        = word_q[i-1];
    end

    if (i == LAST) begin : g_tail
      assign give_ev[i] = unload_ev;
    end else begin : g_pass
      assign give_ev[i] = take_ev[i+1];
    end

    bubble_stage #(.WIDTH(WIDTH)) stage_i (
      .clk      (clk),
      .rst      (rst),
      .take     (take_ev[i]),
      .give     (give_ev[i]),
      .src_word (src),
      .full_q   (mark_q[i]),
      .word_q   (word_q[i])
    );
  end

  bubble_out_gate #(.WIDTH(WIDTH)) gate_i (
    .en    (oe),
    .word  (word_q[LAST]),
    .gated (dout)
  );

endmodule

// File: rtl/bubble_fifo_chk.sv
module bubble_fifo_chk #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             shift_in,
  input logic             shift_out,
  input logic             oe,
  input logic [WIDTH-1:0] dout,
  input logic             in_rdy,
  input logic             out_rdy,
  input logic [DEPTH-1:0] mark,
  input logic             load_ev,
  input logic             unload_ev
);

  a_r1_reset_empty: assert property (@(posedge clk) rst |=> (mark == '0));

  // R2: word count is conserved across every edge.
  a_r2_conserve: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $countones(mark) ==
      $past($countones(mark)) + int'($past(load_ev)) - int'($past(unload_ev)));

  a_r4_drop_full_write: assert property (@(posedge clk) disable iff (rst)
    (shift_in && !in_rdy) |=> $countones(mark) <= $past($countones(mark)));

  a_r5_drop_empty_read: assert property (@(posedge clk) disable iff (rst)
    (shift_out && !out_rdy) |=> $countones(mark) >= $past($countones(mark)));

  a_r7_oe_gates: assert property (@(posedge clk) disable iff (rst)
    !oe |-> (dout == '0));

  a_r9_unload_clears: assert property (@(posedge clk) disable iff (rst)
    (shift_out && out_rdy) |=> !out_rdy);

  // R6 / R8: a vacant stage with an occupied upstream neighbour fills next cycle.
  for (genvar i = 1; i < DEPTH; i++) begin : g_ripple
    a_r6_ripple: assert property (@(posedge clk) disable iff (rst)
      (mark[i-1] && !mark[i]) |=> mark[i]);
  end

endmodule

bind bubble_fifo bubble_fifo_chk #(.DEPTH(DEPTH), .WIDTH(WIDTH)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .shift_in  (shift_in),
  .shift_out (shift_out),
  .oe        (oe),
  .dout      (dout),
  .in_rdy    (in_rdy),
  .out_rdy   (out_rdy),
  .mark      (mark_q),
  .load_ev   (load_ev),
  .unload_ev (unload_ev)
);

// File: tb/bubble_fifo_tb_top.sv
`timescale 1ns/1ps
module bubble_fifo_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       shift_in = 1'b0;
  logic [3:0] din = '0;
  logic       shift_out = 1'b0;
  logic       oe = 1'b1;
  logic [3:0] dout;
  logic       in_rdy;
  logic       out_rdy;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  bubble_fifo #(.DEPTH(16), .WIDTH(4)) dut_i (
    .clk(clk), .rst(rst), .shift_in(shift_in), .din(din),
    .shift_out(shift_out), .oe(oe), .dout(dout),
    .in_rdy(in_rdy), .out_rdy(out_rdy)
  );

  // {word, oe, expected dout}
  localparam logic [8:0] VEC [8] = '{
    {4'h3, 1'b1, 4'h3}, {4'hA, 1'b0, 4'h0}, {4'h5, 1'b1, 4'h5},
    {4'hF, 1'b1, 4'hF}, {4'h0, 1'b1, 4'h0}, {4'hC, 1'b0, 4'h0},
    {4'h7, 1'b1, 4'h7}, {4'h9, 1'b0, 4'h0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [3:0] w);
    for (int n = 0; n < 64 && !in_rdy; n++) @(negedge clk);
    chk("R3 in_rdy before push", {7'b0, in_rdy}, 8'd1);
    shift_in = 1'b1; din = w;
    @(negedge clk);
    shift_in = 1'b0;
  endtask

  task automatic pop(output logic [3:0] w);
    for (int n = 0; n < 64 && !out_rdy; n++) @(negedge clk);
    chk("R2 out_rdy before pop", {7'b0, out_rdy}, 8'd1);
    w = dout;
    shift_out = 1'b1;
    @(negedge clk);
    shift_out = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] w;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R1 in_rdy after reset", {7'b0, in_rdy}, 8'd1);
    chk("R1 out_rdy after reset", {7'b0, out_rdy}, 8'd0);

    // Table walk: R2 order, R7 gating
    for (int i = 0; i < 8; i++) push(VEC[i][8:5]);
    for (int i = 0; i < 8; i++) begin
      for (int n = 0; n < 64 && !out_rdy; n++) @(negedge clk);
      oe = VEC[i][4];
      #1;
      chk("R7/R2 table dout", {4'h0, dout}, {4'h0, VEC[i][3:0]});
      pop(w);
    end
    oe = 1'b1;
    repeat (20) @(negedge clk);
    chk("R7 oe-off pops removed words", {7'b0, out_rdy}, 8'd0);

    // R6 fall-through latency
    shift_in = 1'b1; din = 4'h6;
    @(negedge clk);           // after edge k
    shift_in = 1'b0;
    repeat (14) @(negedge clk); // after edge k+14
    chk("R6 out_rdy at k+14", {7'b0, out_rdy}, 8'd0);
    @(negedge clk);
    chk("R6 out_rdy at k+15", {7'b0, out_rdy}, 8'd1);
    chk("R6 word value", {4'h0, dout}, 8'h06);
    pop(w);
    repeat (20) @(negedge clk);

    // R3 fill to capacity
    for (int i = 0; i < 16; i++) push(4'(i));
    repeat (20) @(negedge clk);
    chk("R3 full in_rdy", {7'b0, in_rdy}, 8'd0);
    chk("R3 full out_rdy", {7'b0, out_rdy}, 8'd1);

    // R4 / R10: write while full, together with a read
    shift_in = 1'b1; din = 4'hE; shift_out = 1'b1;
    @(negedge clk);           // after edge k
    shift_in = 1'b0; shift_out = 1'b0;
    chk("R9 out_rdy cleared at k", {7'b0, out_rdy}, 8'd0);
    @(negedge clk);
    chk("R9 out_rdy refilled at k+1", {7'b0, out_rdy}, 8'd1);
    chk("R9 next word", {4'h0, dout}, 8'h01);
    repeat (13) @(negedge clk); // after edge k+14
    chk("R8 in_rdy at k+14", {7'b0, in_rdy}, 8'd0);
    @(negedge clk);
    chk("R8 in_rdy at k+15", {7'b0, in_rdy}, 8'd1);

    // drain: R2 order, R4/R10 extra word absent
    for (int i = 1; i < 16; i++) begin
      pop(w);
      chk("R2 drain order", {4'h0, w}, {4'h0, 4'(i)});
    end
    repeat (20) @(negedge clk);
    chk("R4/R10 dropped write absent", {7'b0, out_rdy}, 8'd0);

    // R5 read while empty
    shift_out = 1'b1;
    repeat (3) @(negedge clk);
    shift_out = 1'b0;
    chk("R5 still empty", {7'b0, out_rdy}, 8'd0);
    push(4'hB);
    pop(w);
    chk("R5 word after empty reads", {4'h0, w}, 8'h0B);
    repeat (20) @(negedge clk);
    chk("R5 no phantom word", {7'b0, out_rdy}, 8'd0);

    // R1 reset during traffic
    for (int i = 0; i < 5; i++) push(4'hD);
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk("R1 mid reset in_rdy", {7'b0, in_rdy}, 8'd1);
    chk("R1 mid reset out_rdy", {7'b0, out_rdy}, 8'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule